// File: doc/BRIEF.md
# Multiplexed I/O-Bus Memory Transfer Channel

This block moves single words between peripheral devices and main memory over the shared I/O bus. It does not use hardware address counters. Each channel keeps its current word pointer and its last-word limit in a reserved pair of memory words. Servicing one device request therefore costs four memory cycles, in this order:

1. Fetch the pointer.
2. Fetch the limit.
3. Move the data word at the pointer.
4. Store the pointer plus one.

A device raises its request line, and a per-channel direction input sets which way the word moves. The engine waits for the processor to signal an instruction boundary and picks the lowest-numbered eligible channel. It then holds the processor off the memory port for the four cycles. When a channel transfers the word at its limit, the engine pulses an end indication to that device. The channel then stays disarmed until the device or system re-arms it.

Top module: `dmc_engine`

## Requirements
- R1: After reset, `cpu_hold`, `busy`, `mem_req`, `dev_ack` and `dev_end` are all low, and every channel is armed.
- R2: A service sequence starts only in the clock after one in which `instr_boundary` is high while at least one armed channel has its request high. Requests without a boundary wait.
- R3: A service sequence is exactly four consecutive memory cycles. `cpu_hold`, `busy` and `mem_req` are high in all four and low in the following cycle.
- R4: For channel n, cycle 1 reads address BASE+2n (the pointer) and cycle 4 writes the same address. Cycle 2 reads address BASE+2n+1 (the limit). BASE defaults to 0x20.
- R5: When `dev_to_mem[n]` is 0, cycle 3 reads memory at the pointer and presents the word on `dev_wdata`.
- R6: When `dev_to_mem[n]` is 1, cycle 3 writes `dev_rdata` to memory at the pointer.
- R7: Cycle 4 writes the pointer value plus one.
- R8: If the pointer equals the limit, the word is still moved. `dev_end[n]` is then high for exactly cycle 4.
- R9: After an end indication, requests on that channel are ignored until a pulse on `chan_arm[n]`. Other channels are unaffected.
- R10: When several armed channels request together, the lowest-numbered channel is served first.
- R11: `dev_ack` is one-hot, high only in cycle 3, and marks the channel being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_boundary | input | 1 | Processor is between instructions |
| dev_req | input | NCH | Per-channel transfer request |
| dev_to_mem | input | NCH | Per-channel direction, 1 = device to memory |
| chan_arm | input | NCH | Per-channel re-arm pulse |
| dev_rdata | input | DW | Word from the device on the I/O bus |
| dev_wdata | output | DW | Word to the device on the I/O bus |
| dev_ack | output | NCH | Channel whose word moves this cycle |
| dev_end | output | NCH | Limit reached on this channel |
| cpu_hold | output | 1 | Processor kept off the memory port |
| busy | output | 1 | Service sequence in progress |
| mem_req | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle |

## Verification
Several properties are checked on every cycle:
- The sequencer steps through its four phases in order.
- A sequence begins only after a boundary.
- The memory port is active whenever the processor is held.
- An end pulse appears only during the pointer write-back.
- The grant always names the lowest eligible channel.
- A channel is disarmed only by its own end condition.

Some behaviour only the directed scenarios can show:
- The exact addresses of the pointer and limit pair for each channel.
- The data moved in each direction and the incremented pointer left in memory.
- A disarmed channel's request being ignored until it is re-armed.
- The order in which competing channels are served.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PTR  = 3'd1,
      ST_LIM  = 3'd2,
      ST_XFER = 3'd3,
      ST_BACK = 3'd4
   } dmc_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/dmc_arbiter.sv
module dmc_arbiter #(
   parameter int unsigned NCH = 8,
   parameter int unsigned CW  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] elig,
   output logic           gnt_vld,
   output logic [CW-1:0]  gnt_idx
);

   // Scan from the top down so that the lowest set bit is the last one written.
   always_comb begin
      gnt_vld = 1'b0;
      gnt_idx = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (elig[i]) begin
            gnt_vld = 1'b1;
            gnt_idx = CW'(i);
         end
      end
   end

   AST_GNT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> elig[gnt_idx]);                                      // R10
   AST_GNT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld |-> ((elig & ((NCH'(1) << gnt_idx) - NCH'(1))) == '0));  // R10
   AST_GNT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (elig != '0) |-> gnt_vld);                                       // R10

endmodule

// File: rtl/dmc_arm_bank.sv
module dmc_arm_bank #(
   parameter int unsigned NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] arm,
   input  logic [NCH-1:0] end_hit,
   output logic [NCH-1:0] armed
);

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      // A re-arm pulse wins over an end hit in the same cycle.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          armed[g] <= 1'b1;
         else if (arm[g])     armed[g] <= 1'b1;
         else if (end_hit[g]) armed[g] <= 1'b0;
      end

      AST_DISARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(armed[g]) |-> $past(end_hit[g]));                       // R9
      AST_REARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(armed[g]) |-> $past(arm[g]));                           // R9
   end

endmodule

// File: rtl/dmc_sequencer.sv
module dmc_sequencer
   import dmc_pkg::*;
#(
   parameter int unsigned NCH  = 8,
   parameter int unsigned CW   = 3,
   parameter int unsigned AW   = 15,
   parameter int unsigned DW   = 16,
   parameter int unsigned BASE = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           instr_boundary,
   input  logic           gnt_vld,
   input  logic [CW-1:0]  gnt_idx,
   input  logic [NCH-1:0] dev_to_mem,
   input  logic [DW-1:0]  dev_rdata,
   input  logic [DW-1:0]  mem_rdata,
   output logic [DW-1:0]  dev_wdata,
   output logic [NCH-1:0] dev_ack,
   output logic [NCH-1:0] dev_end,
   output logic           cpu_hold,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata
);

   localparam logic [AW-1:0] BASE_A = AW'(BASE);

   dmc_state_t      state;
   logic [CW-1:0]   ch_q;
   logic            to_mem_q;
   logic [DW-1:0]   ptr_q;
   logic [DW-1:0]   lim_q;
   logic [AW-1:0]   slot_addr;
   logic [NCH-1:0]  ch_onehot;
   logic            at_limit;

   assign slot_addr = BASE_A + AW'({ch_q, 1'b0});
   assign ch_onehot = NCH'(1) << ch_q;
   assign at_limit  = (ptr_q == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ch_q     <= '0;
         to_mem_q <= 1'b0;
         ptr_q    <= '0;
         lim_q    <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (instr_boundary && gnt_vld) begin
               state    <= ST_PTR;
               ch_q     <= gnt_idx;
               to_mem_q <= dev_to_mem[gnt_idx];
            end
            ST_PTR: begin
               ptr_q <= mem_rdata;
               state <= ST_LIM;
            end
            ST_LIM: begin
               lim_q <= mem_rdata;
               state <= ST_XFER;
            end
            ST_XFER: state <= ST_BACK;
            ST_BACK: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = (state != ST_IDLE);
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      dev_wdata = '0;
      dev_ack   = '0;
      dev_end   = '0;
      unique case (state)
         ST_PTR: mem_addr = slot_addr;
         ST_LIM: mem_addr = slot_addr + AW'(1);
         ST_XFER: begin
            mem_addr = ptr_q[AW-1:0];
            dev_ack  = ch_onehot;
            if (to_mem_q) begin
               mem_we    = 1'b1;
               mem_wdata = dev_rdata;
            end else begin
               dev_wdata = mem_rdata;
            end
         end
         ST_BACK: begin
            mem_addr  = slot_addr;
            mem_we    = 1'b1;
            mem_wdata = ptr_q + DW'(1);
            if (at_limit) dev_end = ch_onehot;
         end
         default: ;
      endcase
   end

   assign cpu_hold = (state != ST_IDLE);

   AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_hold) |-> $past(instr_boundary));                      // R2
   AST_STEP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PTR) |=> (state == ST_LIM));                        // R3
   AST_STEP_LIM: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LIM) |=> (state == ST_XFER));                       // R3
   AST_STEP_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER) |=> (state == ST_BACK));                      // R3
   AST_STEP_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BACK) |=> (state == ST_IDLE));                      // R3
   AST_HOLD_HAS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hold |-> mem_req);                                           // R3
   AST_END_IN_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_end != '0) |-> (mem_we && $past(state == ST_XFER)));        // R8
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_ack));                                              // R11
   AST_ACK_AFTER_LIM: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack != '0) |-> $past(state == ST_LIM));                     // R11

endmodule

// File: rtl/dmc_engine.sv
module dmc_engine
   import dmc_pkg::*;
#(
   parameter int unsigned NCH  = 8,
   parameter int unsigned AW   = 15,
   parameter int unsigned DW   = 16,
   parameter int unsigned BASE = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           instr_boundary,
   input  logic [NCH-1:0] dev_req,
   input  logic [NCH-1:0] dev_to_mem,
   input  logic [NCH-1:0] chan_arm,
   input  logic [DW-1:0]  dev_rdata,
   output logic [DW-1:0]  dev_wdata,
   output logic [NCH-1:0] dev_ack,
   output logic [NCH-1:0] dev_end,
   output logic           cpu_hold,
   output logic           busy,
   output logic           mem_req,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata
);

   localparam int unsigned CW = idx_width(NCH);

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("dmc_engine: NCH must be between 1 and 8");
   end
   if (BASE + 2 * NCH > (1 << AW)) begin : g_bad_base
      $error("dmc_engine: pointer slots exceed the address space");
   end
   if (DW < AW) begin : g_bad_dw
      $error("dmc_engine: DW must hold a full address");
   end

   logic [NCH-1:0] armed;
   logic [NCH-1:0] elig;
   logic           gnt_vld;
   logic [CW-1:0]  gnt_idx;

   assign elig = dev_req & armed;

   dmc_arm_bank #(.NCH(NCH)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (chan_arm),
      .end_hit (dev_end),
      .armed   (armed)
   );

   dmc_arbiter #(.NCH(NCH), .CW(CW)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig),
      .gnt_vld (gnt_vld),
      .gnt_idx (gnt_idx)
   );

   dmc_sequencer #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW), .BASE(BASE)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .instr_boundary (instr_boundary),
      .gnt_vld        (gnt_vld),
      .gnt_idx        (gnt_idx),
      .dev_to_mem     (dev_to_mem),
      .dev_rdata      (dev_rdata),
      .mem_rdata      (mem_rdata),
      .dev_wdata      (dev_wdata),
      .dev_ack        (dev_ack),
      .dev_end        (dev_end),
      .cpu_hold       (cpu_hold),
      .mem_req        (mem_req),
      .mem_we         (mem_we),
      .mem_addr       (mem_addr),
      .mem_wdata      (mem_wdata)
   );

   assign busy = cpu_hold;

   AST_BUSY_MATCHES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      busy == mem_req);                                                // R3
   AST_ACK_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(elig) != '0));                            // R9

endmodule

// File: tb/dmc_engine_test.sv
module dmc_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 8;
   localparam int AW = 15;
   localparam int DW = 16;
   localparam int BASE = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           instr_boundary = 1'b0;
   logic [NCH-1:0] dev_req = '0;
   logic [NCH-1:0] dev_to_mem = '0;
   logic [NCH-1:0] chan_arm = '0;
   logic [DW-1:0]  dev_rdata = '0;
   logic [DW-1:0]  dev_wdata;
   logic [NCH-1:0] dev_ack;
   logic [NCH-1:0] dev_end;
   logic           cpu_hold;
   logic           busy;
   logic           mem_req;
   logic           mem_we;
   logic [AW-1:0]  mem_addr;
   logic [DW-1:0]  mem_wdata;
   logic [DW-1:0]  mem_rdata;

   logic [DW-1:0]  mem [0:255];
   logic           ld_en = 1'b0;
   logic [7:0]     ld_addr = '0;
   logic [DW-1:0]  ld_data = '0;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else if (ld_en)        mem[ld_addr] <= ld_data;
   end

   dmc_engine #(.NCH(NCH), .AW(AW), .DW(DW), .BASE(BASE)) uut (
      .clk(clk), .rst_n(rst_n), .instr_boundary(instr_boundary),
      .dev_req(dev_req), .dev_to_mem(dev_to_mem), .chan_arm(chan_arm),
      .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
      .dev_end(dev_end), .cpu_hold(cpu_hold), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Writes one memory word while the engine is idle.
   task automatic poke(input logic [7:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // One full service on channel ch, with every cycle checked.
   task automatic do_xfer(input int ch, input bit to_mem, input logic [DW-1:0] ptr,
                          input logic [DW-1:0] lim, input logic [DW-1:0] din);
      logic [AW-1:0]  slot = AW'(BASE + 2 * ch);
      logic [DW-1:0]  old_word = mem[ptr[7:0]];
      logic [NCH-1:0] oh = NCH'(1) << ch;
      @(negedge clk);
      dev_req[ch] = 1'b1; dev_to_mem[ch] = to_mem; dev_rdata = din;
      instr_boundary = 1'b1;
      @(negedge clk);
      instr_boundary = 1'b0;
      chk(cpu_hold && busy && mem_req && !mem_we, "R3 cycle1 hold", {cpu_hold, busy, mem_req, mem_we}, 4'b1110);
      chk(mem_addr == slot, "R4 pointer read address", mem_addr, slot);
      @(negedge clk);
      chk(mem_addr == slot + 1 && !mem_we, "R4 limit read address", mem_addr, slot + 1);
      @(negedge clk);
      chk(dev_ack == oh, "R11 ack in cycle3", dev_ack, oh);
      chk(mem_addr == ptr[AW-1:0] && mem_we == to_mem, "R5 R6 data cycle", {mem_we, mem_addr}, {to_mem, ptr[AW-1:0]});
      if (!to_mem) chk(dev_wdata == old_word, "R5 word to device", dev_wdata, old_word);
      dev_req[ch] = 1'b0;
      @(negedge clk);
      chk(mem_we && mem_addr == slot && mem_wdata == ptr + 1, "R7 pointer write-back", mem_wdata, ptr + 1);
      chk(dev_end == ((ptr == lim) ? oh : '0), "R8 end pulse", dev_end, (ptr == lim) ? oh : '0);
      chk(dev_ack == '0, "R11 ack gone", dev_ack, 0);
      @(negedge clk);
      chk(!cpu_hold && !busy && !mem_req && dev_end == '0, "R3 released after 4", {cpu_hold, mem_req}, 0);
      chk(mem[slot[7:0]] == ptr + 1, "R7 pointer in memory", mem[slot[7:0]], ptr + 1);
      if (to_mem) chk(mem[ptr[7:0]] == din, "R6 word in memory", mem[ptr[7:0]], din);
   endtask

   task automatic t_reset;
      chk(!cpu_hold && !busy && !mem_req, "R1 reset idle", {cpu_hold, busy, mem_req}, 0);
      chk(dev_ack == '0 && dev_end == '0, "R1 reset device lines", {dev_ack, dev_end}, 0);
   endtask

   task automatic t_read_to_device;
      poke(8'h24, 16'h0080); poke(8'h25, 16'h0090); poke(8'h80, 16'hBEEF);
      do_xfer(2, 1'b0, 16'h0080, 16'h0090, 16'h0000);
   endtask

   task automatic t_write_from_device;
      poke(8'h2A, 16'h00A0); poke(8'h2B, 16'h00A5);
      do_xfer(5, 1'b1, 16'h00A0, 16'h00A5, 16'h1234);
   endtask

   task automatic t_wait_boundary;
      bit stayed = 1'b1;
      @(negedge clk);
      dev_req[4] = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (cpu_hold || mem_req) stayed = 1'b0;
      end
      chk(stayed, "R2 no start without boundary", {31'd0, stayed}, 1);
      poke(8'h28, 16'h00C0); poke(8'h29, 16'h00CF);
      do_xfer(4, 1'b0, 16'h00C0, 16'h00CF, 16'h0000);
   endtask

   task automatic t_priority;
      poke(8'h22, 16'h0040); poke(8'h23, 16'h0050); poke(8'h40, 16'h1111);
      poke(8'h26, 16'h0060); poke(8'h27, 16'h0070); poke(8'h60, 16'h3333);
      @(negedge clk);
      dev_req[3] = 1'b1;
      do_xfer(1, 1'b0, 16'h0040, 16'h0050, 16'h0000);
      chk(mem[8'h26] == 16'h0060, "R10 higher channel not yet served", mem[8'h26], 16'h0060);
      do_xfer(3, 1'b0, 16'h0060, 16'h0070, 16'h0000);
   endtask

   task automatic t_end_and_rearm;
      bit stayed = 1'b1;
      poke(8'h20, 16'h0030); poke(8'h21, 16'h0030);
      do_xfer(0, 1'b1, 16'h0030, 16'h0030, 16'h5A5A);
      @(negedge clk);
      dev_req[0] = 1'b1; instr_boundary = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (cpu_hold || mem_req) stayed = 1'b0;
      end
      instr_boundary = 1'b0;
      chk(stayed, "R9 disarmed channel ignored", {31'd0, stayed}, 1);
      chk(mem[8'h20] == 16'h0031, "R9 pointer untouched while disarmed", mem[8'h20], 16'h0031);
      dev_req[0] = 1'b0;
      @(negedge clk);
      chk(!cpu_hold, "R9 still idle", {31'd0, cpu_hold}, 0);
      chan_arm[0] = 1'b1;
      @(negedge clk);
      chan_arm[0] = 1'b0;
      poke(8'h21, 16'h0040);
      do_xfer(0, 1'b1, 16'h0031, 16'h0040, 16'h6B6B);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_read_to_device;
      t_write_from_device;
      t_wait_boundary;
      t_priority;
      t_end_and_rearm;
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule